// File: doc/BRIEF.md
# Serial Converter Read and Power-Down Sequencer

This block is the host end of a three-wire link to a 12-bit sampling converter. It drives the active-low chip select and the serial clock, and it reads the serial data line. A request carries one bit of intent. A read request runs a full sixteen-clock frame. The block drops the four leading bits it shifts in and presents the remaining twelve as the result, together with a one-cycle valid strobe. A sleep request runs a deliberately short frame of six serial clocks. Raising chip select inside the converter's power-down window parks the converter in its low-power state, and no result is produced.

The serial clock is derived from the system clock. It runs at a half-period of a programmable number of system clocks, and a programmed zero behaves as one, so the fastest rate is divide-by-two. After every frame, chip select stays high for a programmable quiet interval before another frame may begin. Ready is low for the whole of a frame and its quiet interval, so requests made then simply wait. A mode output follows the converter's power state. It drops when a sleep frame completes and rises again as soon as any frame starts, because the converter wakes on the chip-select falling edge. Divider and quiet settings are captured when a request is accepted.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, chip select is high, serial clock is high, ready is high, result valid is low and the mode output reads awake (1).
- R2: A read frame (request sleep bit 0) holds chip select low across exactly 16 serial-clock falling edges and for exactly 32*H system clocks, where H is the effective half-period.
- R3: A sleep frame (request sleep bit 1) holds chip select low across exactly 6 serial-clock falling edges (2*6*H system clocks), and then raises it before any 7th falling edge.
- R4: The data line is sampled on serial-clock rising edges. The first 4 samples are discarded and the last 12 form the result, with the earliest of them in bit 11. Result valid is high for exactly one cycle, the first cycle after chip select rises at the end of a read frame. A sleep frame never raises result valid.
- R5: After a frame ends, chip select stays high for Q+1 system clocks before a waiting request starts the next frame, where Q is the captured quiet count (a programmed 0 acts as 1).
- R6: Ready is low from the cycle after a request is accepted until the quiet interval ends. A frame starts (chip select falls) only on the cycle after the request valid and ready signals are both high.
- R7: The mode output becomes 0 when a sleep frame ends and becomes 1 in the same cycle that chip select falls for any frame.
- R8: The effective half-period H equals the half-period setting, except that a setting of 0 acts as 1.
- R9: The serial clock is high whenever chip select is high, and its first falling edge comes H system clocks after chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Frame request |
| req_sleep | input | 1 | 0 = read frame, 1 = power-down frame |
| req_ready | output | 1 | Sequencer can accept a request |
| cfg_half | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| cfg_quiet | input | 8 | Quiet interval in system clocks (0 acts as 1) |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | 12 | Conversion result |
| conv_awake | output | 1 | Tracked converter mode: 1 normal, 0 shut down |

## Verification
The hardest case to reach is the quiet gap between two frames while a request is already waiting. It only shows its true length if the request is held high across the end of one frame and through the whole quiet count. The bench therefore keeps the request asserted over two consecutive frames and times the chip-select high run. It does this once with a nonzero quiet count and once with zero, so that the clamp to one is also covered. A converter model on the bench shifts data out on each serial-clock falling edge, and its leading bits are nonzero, so a result that kept any leading bit would show up. Sleep frames are placed directly before read frames so that the drop of the mode output and its recovery at the next chip-select fall are both observed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_QUIET = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_seq_tick.sv
// Half-period timer for the serial clock: pulses tick every `half` enabled cycles.
module adc_seq_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == half - DIV_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_seq_shift.sv
// Result shifter: only the newest RES_W samples are kept, so leading bits fall off.
module adc_seq_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             din,
    output logic [RES_W-1:0] word_next
);

    logic [RES_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clear) begin
            sr_d = '0;
        end else if (sample) begin
            sr_d = {sr_q[RES_W-2:0], din};
        end
    end

    assign word_next = sr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int QUIET_W     = 8,
    parameter int FRAME_BITS  = 16,
    parameter int RES_W       = 12,
    parameter int SLEEP_EDGES = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_sleep,
    output logic               req_ready,
    input  logic [DIV_W-1:0]   cfg_half,
    input  logic [QUIET_W-1:0] cfg_quiet,
    output logic               adc_cs_n,
    output logic               adc_sclk,
    input  logic               adc_sdata,
    output logic               rd_valid,
    output logic [RES_W-1:0]   rd_data,
    output logic               conv_awake
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] SLEEP_CNT = CNT_W'(SLEEP_EDGES);

    typedef struct packed {
        seq_state_e         state;
        logic               cs_n;
        logic               sclk;
        logic [CNT_W-1:0]   falls;
        logic               sleep;
        logic [DIV_W-1:0]   half;
        logic [QUIET_W-1:0] quiet;
        logic [QUIET_W-1:0] qcnt;
        logic               valid;
        logic [RES_W-1:0]   data;
        logic               awake;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tick;
    logic             tick_en;
    logic             sh_clear;
    logic             sh_sample;
    logic [RES_W-1:0] word_next;
    logic [CNT_W-1:0] target;

    assign tick_en = (r_q.state == ST_LEAD) || (r_q.state == ST_RUN);
    assign target  = r_q.sleep ? SLEEP_CNT : FULL_CNT;

    adc_seq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .half  (r_q.half),
        .tick  (tick)
    );

    adc_seq_shift #(.RES_W(RES_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .sample    (sh_sample),
        .din       (adc_sdata),
        .word_next (word_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        sh_clear  = 1'b0;
        sh_sample = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_LEAD;
                    r_d.cs_n  = 1'b0;
                    r_d.sclk  = 1'b1;
                    r_d.falls = '0;
                    r_d.sleep = req_sleep;
                    r_d.half  = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
                    r_d.quiet = (cfg_quiet == '0) ? QUIET_W'(1) : cfg_quiet;
                    r_d.awake = 1'b1;
                    sh_clear  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    r_d.sclk  = 1'b0;
                    r_d.falls = CNT_W'(1);
                    r_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk  = 1'b0;
                        r_d.falls = r_q.falls + CNT_W'(1);
                    end else begin
                        r_d.sclk  = 1'b1;
                        sh_sample = 1'b1;
                        if (r_q.falls == target) begin
                            r_d.cs_n  = 1'b1;
                            r_d.state = ST_QUIET;
                            r_d.qcnt  = '0;
                            if (r_q.sleep) begin
                                r_d.awake = 1'b0;
                            end else begin
                                r_d.valid = 1'b1;
                                r_d.data  = word_next;
                            end
                        end
                    end
                end
            end
            ST_QUIET: begin
                if (r_q.qcnt == r_q.quiet - QUIET_W'(1)) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.qcnt = r_q.qcnt + QUIET_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sclk  <= 1'b1;
            r_q.half  <= DIV_W'(1);
            r_q.quiet <= QUIET_W'(1);
            r_q.awake <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == ST_IDLE);
    assign adc_cs_n   = r_q.cs_n;
    assign adc_sclk   = r_q.sclk;
    assign rd_valid   = r_q.valid;
    assign rd_data    = r_q.data;
    assign conv_awake = r_q.awake;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic rd_valid,
    input logic conv_awake
);

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> !req_ready);

    p_start_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(req_valid && req_ready));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_valid_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(adc_cs_n));

    p_awake_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> conv_awake);

endmodule

bind adc_frame_seq adc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .rd_valid   (rd_valid),
    .conv_awake (conv_awake)
);

// File: tb/adc_frame_seq_test.sv
module adc_frame_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_sleep = 1'b0;
    logic        req_ready;
    logic [7:0]  cfg_half = 8'd1;
    logic [7:0]  cfg_quiet = 8'd4;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_sdata;
    logic        rd_valid;
    logic [11:0] rd_data;
    logic        conv_awake;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sleep(req_sleep),
        .req_ready(req_ready), .cfg_half(cfg_half), .cfg_quiet(cfg_quiet),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .conv_awake(conv_awake)
    );

    // Converter model: after the k-th falling edge it presents word bit 16-k.
    logic [15:0] model_word = 16'h0;
    int bit_idx = 0;
    always @(negedge adc_cs_n or negedge adc_sclk) begin
        if (adc_sclk) bit_idx = 0;
        else          bit_idx = bit_idx + 1;
    end
    assign adc_sdata = (!adc_cs_n && bit_idx >= 1 && bit_idx <= 16) ? model_word[16 - bit_idx] : 1'b0;

    // Port monitor, sampled away from the active edge.
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    int low_cnt = 0, fall_cnt = 0, first_fall = 0, hi_cnt = 0, gap_last = 0;
    int vcnt = 0, busy_err = 0, frames = 0;
    logic [11:0] vdata = '0;
    logic awake_start = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !adc_cs_n) begin
                low_cnt = 0; fall_cnt = 0; first_fall = 0; vcnt = 0;
                gap_last = hi_cnt; awake_start = conv_awake; frames = frames + 1;
            end
            if (!adc_cs_n) begin
                low_cnt = low_cnt + 1;
                hi_cnt = 0;
                if (prev_sclk && !adc_sclk) begin
                    fall_cnt = fall_cnt + 1;
                    if (fall_cnt == 1) first_fall = low_cnt;
                end
                if (req_ready) busy_err = busy_err + 1;
            end else begin
                hi_cnt = hi_cnt + 1;
            end
            if (rd_valid) begin
                vcnt = vcnt + 1;
                vdata = rd_data;
            end
        end
        prev_cs = adc_cs_n;
        prev_sclk = adc_sclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input bit sl, input logic [7:0] h, input logic [7:0] q, input logic [15:0] w);
        int heff;
        int n;
        heff = (h == 0) ? 1 : int'(h);
        n = sl ? 6 : 16;
        model_word = w;
        cfg_half = h;
        cfg_quiet = q;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_sleep = sl;
        @(negedge clk);
        req_valid = 1'b0;
        while (!adc_cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        check(fall_cnt == n, sl ? "R3 falling edges" : "R2 falling edges", fall_cnt, n);
        check(low_cnt == 2 * n * heff, sl ? "R3 CS low time" : "R2/R8 CS low time", low_cnt, 2 * n * heff);
        check(first_fall == heff + 1, "R9/R8 first fall delay", first_fall, heff + 1);
        check(vcnt == (sl ? 0 : 1), "R4 valid pulses", vcnt, sl ? 0 : 1);
        if (!sl) check(vdata == w[11:0], "R4 result data", int'(vdata), int'(w[11:0]));
        check(awake_start == 1'b1, "R7 awake at frame start", int'(awake_start), 1);
        check(conv_awake == !sl, "R7 mode after frame", int'(conv_awake), int'(!sl));
        check(busy_err == 0, "R6 ready low during frame", busy_err, 0);
    endtask

    task automatic gap_test(input logic [7:0] q);
        int start_frames;
        int qeff;
        qeff = (q == 0) ? 1 : int'(q);
        cfg_half = 8'd1;
        cfg_quiet = q;
        model_word = 16'h1357;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start_frames = frames;
        req_sleep = 1'b0;
        req_valid = 1'b1;
        while (frames < start_frames + 2) @(negedge clk);
        req_valid = 1'b0;
        check(gap_last == qeff + 1, "R5 quiet gap", gap_last, qeff + 1);
        while (!adc_cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy_err == 0, "R6 held-off request", busy_err, 0);
        check(vdata == 12'h357, "R4 back-to-back data", int'(vdata), 12'h357);
    endtask

    // sleep, half, quiet, converter word
    localparam logic [32:0] VEC [0:7] = '{
        {1'b0, 8'd1, 8'd4, 16'hA5C3},
        {1'b0, 8'd2, 8'd3, 16'hF123},
        {1'b1, 8'd1, 8'd4, 16'h0FFF},
        {1'b0, 8'd3, 8'd1, 16'h0800},
        {1'b1, 8'd2, 8'd2, 16'h0001},
        {1'b0, 8'd0, 8'd4, 16'h5FFE},
        {1'b0, 8'd1, 8'd0, 16'h3ABC},
        {1'b1, 8'd0, 8'd0, 16'h1234}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
        check(adc_sclk == 1'b1, "R1 sclk", int'(adc_sclk), 1);
        check(req_ready == 1'b0 || req_ready == 1'b1, "R1 ready known", int'(req_ready), 1);
        check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(conv_awake == 1'b1, "R1 awake", int'(conv_awake), 1);
        check(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 idle lines", int'(adc_cs_n & adc_sclk), 1);

        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]);
        end

        // R5/R6: request held across frames, nonzero and zero quiet counts
        gap_test(8'd5);
        gap_test(8'd0);

        // R9 idle after everything
        check(adc_sclk == 1'b1 && adc_cs_n == 1'b1, "R9 idle high", int'(adc_sclk), 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks = n_checks + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule